// File: doc/BRIEF.md
# Base-and-Bound Address Translator

This block maps a logical address issued by the processor onto a physical address. It holds a single relocation pair for the process that is currently running. The first register is the base, which is the physical start of that process's memory region. The second is the bound, which is the size of the region in bytes. Any address-producing source can present a request: the program counter, the stack pointer or a data pointer. Each request is checked at both ends. An address whose top bit is set counts as negative and is rejected, and so is an address at or above the bound. A rejected access produces a protection fault for the trap logic and never a wrapped or clipped address.

An accepted address is added to the base and comes back one cycle after the request. Software reloads the pair on every process switch through a small write port. That port is honoured only in privileged mode. A write attempted from user mode leaves both registers untouched and raises a one-cycle privilege-fault pulse. After reset both registers are zero, so every request faults until the pair has been programmed.

Top module: `bb_translator`

## Requirements
- R1: After reset `rsp_valid`, `rsp_fault` and `priv_fault` are low, and base and bound are zero. Any request then returns `rsp_fault`=1 with `rsp_paddr`=0.
- R2: `rsp_valid` is high in the cycle that follows a cycle with `req_valid` high, and low otherwise. Back-to-back requests give back-to-back responses in the same order.
- R3: When the request passes both checks, `rsp_paddr` equals `req_laddr` plus base, modulo 2^32, and `rsp_fault` is 0.
- R4: A request with bit 31 of `req_laddr` set returns `rsp_fault`=1 and `rsp_paddr`=0, whatever the bound is.
- R5: A non-negative request with `req_laddr` >= bound (unsigned) returns `rsp_fault`=1 and `rsp_paddr`=0. `req_laddr` = bound-1 is accepted.
- R6: A write with `cfg_we`=1 and `priv_user`=0 loads `cfg_wdata` into the base when `cfg_sel`=0, or into the bound when `cfg_sel`=1. The new value applies to requests from the next cycle on. A request in the same cycle as the write uses the old values.
- R7: A write with `cfg_we`=1 and `priv_user`=1 changes neither register. It raises `priv_fault` for exactly the following cycle.
- R8: When `rsp_valid` is low, `rsp_fault` and `rsp_paddr` are zero. Each faulting request raises `rsp_fault` for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 base, 1 bound |
| cfg_wdata | input | 32 | Value to write |
| priv_user | input | 1 | Current mode: 1 user, 0 privileged |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 32 | Logical address, treated as signed |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Protection fault pulse for the request |
| priv_fault | output | 1 | Pulse after a user-mode register write |

## Verification
A base register holding a wrong value shows up on the very next accepted response as a shifted `rsp_paddr`. A wrong bound appears only when an address near the edge of the region is presented. The tests therefore probe bound-1 and bound directly after every reload. A user-mode write that leaks into a register stays invisible until a later translation, so the bench follows each such write with a request whose expected result depends on the unchanged value. A slip in the same-cycle ordering between a write and a request shows as a single wrong response in the cycle right after the write.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int BB_AW = 32;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_BOUND = 1'b1
    } bb_sel_e;
endpackage

// File: rtl/bb_regfile.sv
module bb_regfile
    import bb_pkg::*;
#(
    parameter int AW = BB_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          priv_user,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] bound_o,
    output logic          priv_fault_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] bound;
        logic          pfault;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pfault = cfg_we && priv_user;
        if (cfg_we && !priv_user) begin
            if (bb_sel_e'(cfg_sel) == SEL_BASE) st_d.base  = cfg_wdata;
            else                               st_d.bound = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o       = st_q.base;
    assign bound_o      = st_q.bound;
    assign priv_fault_o = st_q.pfault;

    // R7
    user_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && priv_user) |=> ($stable(base_o) && $stable(bound_o)));

    // R6
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !priv_user && !cfg_sel) |=> (base_o == $past(cfg_wdata)));

    // R6
    bound_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !priv_user && cfg_sel) |=> (bound_o == $past(cfg_wdata)));
endmodule

// File: rtl/bb_check.sv
module bb_check #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] bound,
    output logic          fault,
    output logic [AW-1:0] paddr
);
    logic neg;
    logic over;

    always_comb begin
        neg   = laddr[AW-1];
        over  = (laddr >= bound);
        fault = neg || over;
        paddr = fault ? '0 : (laddr + base);
    end
endmodule

// File: rtl/bb_translator.sv
module bb_translator
    import bb_pkg::*;
#(
    parameter int AW = BB_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          priv_user,
    input  logic          req_valid,
    input  logic [AW-1:0] req_laddr,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_fault,
    output logic          priv_fault
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] paddr;
        logic          flt;
    } rsp_t;

    logic [AW-1:0] base_w, bound_w, paddr_w;
    logic          fault_w;
    rsp_t          rsp_d, rsp_q;

    bb_regfile #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .priv_user    (priv_user),
        .base_o       (base_w),
        .bound_o      (bound_w),
        .priv_fault_o (priv_fault)
    );

    bb_check #(.AW(AW)) u_chk (
        .laddr (req_laddr),
        .base  (base_w),
        .bound (bound_w),
        .fault (fault_w),
        .paddr (paddr_w)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.vld   = 1'b1;
            rsp_d.flt   = fault_w;
            rsp_d.paddr = paddr_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.flt;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8
    fault_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    // R4
    negative_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_laddr[AW-1]) |=> (rsp_fault && rsp_paddr == '0));

    // R7
    priv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && priv_user) |=> priv_fault);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && !rsp_fault));
endmodule

// File: tb/sim_bb_translator.sv
module sim_bb_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0, priv_user = 1'b0, req_valid = 1'b0;
    logic [31:0] cfg_wdata = '0, req_laddr = '0;
    logic        rsp_valid, rsp_fault, priv_fault;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    logic exp_priv = 1'b0;
    logic [31:0] m_base = '0, m_bound = '0;
    bit done = 0;

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    bb_translator u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .priv_user(priv_user), .req_valid(req_valid),
        .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .priv_fault(priv_fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle; expected response computed from the bench's own register model
    task automatic step(input bit we, input bit sel, input logic [31:0] wd, input bit user,
                        input bit rv, input logic [31:0] la, input string tag);
        item_t it;
        @(posedge clk); #2;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; priv_user = user;
        req_valid = rv; req_laddr = la;
        if (rv) begin
            it.fault = la[31] || (la >= m_bound);
            it.paddr = it.fault ? 32'h0 : la + m_base;
            it.tag   = tag;
            sb.push_back(it);
        end
        if (we && !user) begin
            if (sel) m_bound = wd;
            else     m_base  = wd;
        end
    endtask

    task automatic req(input logic [31:0] la, input string tag);
        step(0, 0, 0, 0, 1, la, tag);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, "");
    endtask

    always @(posedge clk) exp_priv <= rst_n && cfg_we && priv_user;

    // Monitor: compare every cycle away from the edge
    initial forever begin
        @(posedge clk); #5;
        if (rst_n) begin
            chk(priv_fault == exp_priv, "R7 priv_fault", {31'b0, priv_fault}, {31'b0, exp_priv});
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R2 unexpected response", 32'd1, 32'd0);
                end else begin
                    item_t e;
                    e = sb.pop_front();
                    chk(rsp_fault == e.fault, {e.tag, " fault"}, {31'b0, rsp_fault}, {31'b0, e.fault});
                    chk(rsp_paddr == e.paddr, {e.tag, " paddr"}, rsp_paddr, e.paddr);
                end
            end else begin
                chk(rsp_fault == 1'b0 && rsp_paddr == 32'h0, "R8 idle outputs", rsp_paddr, 32'h0);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #35 rst_n = 1'b1;
        @(posedge clk); #5;
        // R1 reset state
        chk(!rsp_valid && !rsp_fault && !priv_fault, "R1 reset outputs",
            {29'b0, rsp_valid, rsp_fault, priv_fault}, 32'h0);
        req(32'h0, "R1 zero bound");
        // R7 user-mode write ignored
        step(1, 0, 32'h0000_1000, 1, 0, 0, "");
        step(1, 1, 32'h0000_0100, 1, 0, 0, "");
        req(32'h0, "R7 still unprogrammed");
        // R6 privileged loads
        step(1, 0, 32'h4000_0000, 0, 0, 0, "");
        step(1, 1, 32'h0000_0100, 0, 0, 0, "");
        req(32'h0000_0000, "R3 start");
        req(32'h0000_00FF, "R5 bound-1");
        req(32'h0000_0100, "R5 at bound");
        req(32'h8000_0000, "R4 min negative");
        req(32'hFFFF_FFFF, "R4 minus one");
        req(32'h0000_0042, "R2 back to back");
        idle();
        // R6 same-cycle write and request uses old bound
        step(1, 1, 32'h0000_0200, 0, 1, 32'h0000_0150, "R6 old bound");
        req(32'h0000_0150, "R6 new bound");
        // R7 user write with a request in flight, then verify bound unchanged
        step(1, 1, 32'h0000_0010, 1, 1, 32'h0000_01FF, "R7 same cycle");
        req(32'h0000_01FF, "R7 bound kept");
        // R3 wrap-around of the sum
        step(1, 0, 32'hFFFF_FF00, 0, 0, 0, "");
        req(32'h0000_0010, "R3 no wrap");
        req(32'h0000_0150, "R3 wrap");
        // R5 and R4 with a maximal bound
        step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, "");
        req(32'h7FFF_FFFF, "R5 max positive");
        req(32'h8000_0001, "R4 large bound");
        idle(); idle(); idle();
        chk(sb.size() == 0, "R2 all responses seen", sb.size(), 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule